// File: doc/BRIEF.md
# SPI FIFO Level, Threshold and Interrupt Unit

This block keeps the occupancy counts of the transmit and receive FIFOs of an SPI controller. It holds one programmable threshold for each direction and derives a five-bit status word and a five-source interrupt vector from those counts. The FIFO storage and the serial shifter are outside the block. The block only sees one-cycle strobes: software pushing transmit words, the engine taking them, the engine delivering receive words, and software reading them. It also sees register write strobes for the thresholds, the interrupt enable mask and the clear register.

Two kinds of interrupt source share the vector. The transmit-low and receive-high sources follow the FIFO levels against the thresholds and clear themselves. The transmit overflow, receive underflow and receive overflow sources are error events that stay latched until software clears them. The clear register uses its own four-bit layout, which includes a bit that clears every latched error at once. A threshold write is accepted only when its value is smaller than the FIFO depth. Software can therefore find the depth by writing rising values and reading them back.

Top module: `spi_fis_top`

## Requirements
- R1: After synchronous reset both levels, both thresholds, the mask and all latched error bits are 0. So `raw_irq` is 5'b00001, `irq` is 0 and `status` is 5'b01100.
- R2: A push into a FIFO that is not full raises its level by one, and a pop from a FIFO that is not empty lowers it by one. The levels appear on `tx_level` and `rx_level` one clock after the strobe.
- R3: `tx_push` while `tx_level` equals DEPTH is dropped, so the level stays the same, and it sets raw bit 1 (transmit overflow).
- R4: `rx_pop` while `rx_level` is 0 leaves the level at 0 and sets raw bit 2 (receive underflow).
- R5: `rx_push` while `rx_level` equals DEPTH is dropped and sets raw bit 3 (receive overflow).
- R6: Raw bits 1 to 3 stay set until cleared through the clear register. Clear bit 0 clears all three, bit 1 clears receive underflow, bit 2 clears receive overflow and bit 3 clears transmit overflow. If an error event and its clear happen in the same cycle, the bit stays set.
- R7: Raw bit 0 is 1 exactly when `tx_level` is less than or equal to the transmit threshold.
- R8: Raw bit 4 is 1 exactly when `rx_level` is greater than the receive threshold.
- R9: A threshold write with a value of DEPTH or more is ignored and the threshold keeps its old value. A smaller value is stored and shows on the threshold output the next cycle.
- R10: `masked_irq` is `raw_irq` AND the mask, where a mask bit of 1 enables that source. `irq` is the OR of `masked_irq`.
- R11: `status` bit 0 is busy (`engine_busy` or a non-empty transmit FIFO), bit 1 is transmit full, bit 2 is transmit empty, bit 3 is receive empty and bit 4 is receive full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_push | input | 1 | Software writes a transmit word |
| tx_pop | input | 1 | Engine takes a transmit word |
| rx_push | input | 1 | Engine delivers a receive word |
| rx_pop | input | 1 | Software reads a receive word |
| engine_busy | input | 1 | Serial engine is shifting |
| tx_thr_wr | input | 1 | Write strobe, transmit threshold |
| rx_thr_wr | input | 1 | Write strobe, receive threshold |
| thr_wdata | input | 5 | Threshold write value |
| mask_wr | input | 1 | Write strobe, interrupt enable mask |
| mask_wdata | input | 5 | Mask write value |
| clr_wr | input | 1 | Write strobe, clear register |
| clr_wdata | input | 4 | Clear register write value (write one to clear) |
| tx_level | output | 5 | Transmit FIFO occupancy |
| rx_level | output | 5 | Receive FIFO occupancy |
| tx_thr | output | 5 | Transmit threshold readback |
| rx_thr | output | 5 | Receive threshold readback |
| irq_mask | output | 5 | Mask readback |
| raw_irq | output | 5 | Unmasked interrupt vector |
| masked_irq | output | 5 | Enabled interrupt vector |
| irq | output | 1 | Combined interrupt |
| status | output | 5 | Status word |

## Verification
The hardest cases to reach are the error sources. Each one needs a FIFO driven fully to its DEPTH limit, or fully drained, before the offending strobe arrives. The cross-mapped clear register must then be shown to clear only the intended latched bit. The bench fills each FIFO with a counted run of strobes past DEPTH and drains it back to zero. It then tries each clear bit alone, including one whose clear coincides with a fresh underflow. Threshold rejection is reached by writing DEPTH and then DEPTH minus one while the receive FIFO sits full, so the receive-high source shows which value was kept.

// File: rtl/spi_fis_pkg.sv
package spi_fis_pkg;

    localparam int WD_W  = 5;
    localparam int CLR_W = 4;

    // interrupt vector, bit 0 at the bottom
    typedef struct packed {
        logic rx_high;
        logic rx_ovf;
        logic rx_unf;
        logic tx_ovf;
        logic tx_low;
    } irq_vec_t;

    typedef struct packed {
        logic rx_full;
        logic rx_empty;
        logic tx_empty;
        logic tx_full;
        logic busy;
    } stat_vec_t;

    // clear register layout
    localparam int CLR_ALL = 0;
    localparam int CLR_UNF = 1;
    localparam int CLR_ROV = 2;
    localparam int CLR_TOV = 3;

    function automatic logic thr_legal(input logic [WD_W-1:0] v, input int depth);
        return int'(v) < depth;
    endfunction

endpackage

// File: rtl/spi_fis_level.sv
module spi_fis_level
    import spi_fis_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic            pop,
    output logic [WD_W-1:0] level,
    output logic            full,
    output logic            empty,
    output logic            push_lost,
    output logic            pop_starved
);
    localparam logic [WD_W-1:0] TOP = WD_W'(DEPTH);

    logic take_push, take_pop;

    assign full        = (level == TOP);
    assign empty       = (level == '0);
    assign take_push   = push && !full;
    assign take_pop    = pop && !empty;
    assign push_lost   = push && full;
    assign pop_starved = pop && empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
        end else if (take_push != take_pop) begin
            level <= take_push ? level + 1'b1 : level - 1'b1;
        end
    end
endmodule

// File: rtl/spi_fis_thresh.sv
module spi_fis_thresh
    import spi_fis_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [WD_W-1:0] wdata,
    output logic [WD_W-1:0] thr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            thr <= '0;
        end else if (wr && thr_legal(wdata, DEPTH)) begin
            thr <= wdata;
        end
    end
endmodule

// File: rtl/spi_fis_irq.sv
module spi_fis_irq
    import spi_fis_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [WD_W-1:0]  tx_level,
    input  logic [WD_W-1:0]  rx_level,
    input  logic [WD_W-1:0]  tx_thr,
    input  logic [WD_W-1:0]  rx_thr,
    input  logic             ev_tx_ovf,
    input  logic             ev_rx_unf,
    input  logic             ev_rx_ovf,
    input  logic             mask_wr,
    input  logic [WD_W-1:0]  mask_wdata,
    input  logic             clr_wr,
    input  logic [CLR_W-1:0] clr_wdata,
    output logic [WD_W-1:0]  mask_q,
    output irq_vec_t         raw,
    output irq_vec_t         enabled
);
    logic tx_ovf_q, rx_unf_q, rx_ovf_q;
    logic kill_tov, kill_unf, kill_rov;

    assign kill_tov = clr_wr && (clr_wdata[CLR_ALL] || clr_wdata[CLR_TOV]);
    assign kill_unf = clr_wr && (clr_wdata[CLR_ALL] || clr_wdata[CLR_UNF]);
    assign kill_rov = clr_wr && (clr_wdata[CLR_ALL] || clr_wdata[CLR_ROV]);

    // a new event beats a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_ovf_q <= 1'b0;
            rx_unf_q <= 1'b0;
            rx_ovf_q <= 1'b0;
            mask_q   <= '0;
        end else begin
            tx_ovf_q <= ev_tx_ovf || (tx_ovf_q && !kill_tov);
            rx_unf_q <= ev_rx_unf || (rx_unf_q && !kill_unf);
            rx_ovf_q <= ev_rx_ovf || (rx_ovf_q && !kill_rov);
            if (mask_wr) mask_q <= mask_wdata;
        end
    end

    always_comb begin
        raw.tx_low  = (tx_level <= tx_thr);
        raw.tx_ovf  = tx_ovf_q;
        raw.rx_unf  = rx_unf_q;
        raw.rx_ovf  = rx_ovf_q;
        raw.rx_high = (rx_level > rx_thr);
        enabled     = irq_vec_t'(raw & irq_vec_t'(mask_q));
    end
endmodule

// File: rtl/spi_fis_top.sv
module spi_fis_top
    import spi_fis_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_push,
    input  logic             tx_pop,
    input  logic             rx_push,
    input  logic             rx_pop,
    input  logic             engine_busy,
    input  logic             tx_thr_wr,
    input  logic             rx_thr_wr,
    input  logic [4:0]       thr_wdata,
    input  logic             mask_wr,
    input  logic [4:0]       mask_wdata,
    input  logic             clr_wr,
    input  logic [3:0]       clr_wdata,
    output logic [4:0]       tx_level,
    output logic [4:0]       rx_level,
    output logic [4:0]       tx_thr,
    output logic [4:0]       rx_thr,
    output logic [4:0]       irq_mask,
    output logic [4:0]       raw_irq,
    output logic [4:0]       masked_irq,
    output logic             irq,
    output logic [4:0]       status
);
    initial begin
        if (DEPTH < 2 || DEPTH > 31) $error("DEPTH must be within 2..31");
    end

    logic tx_full, tx_empty, rx_full, rx_empty;
    logic tx_lost, tx_starved_unused, rx_lost, rx_starved;
    irq_vec_t  raw_v, en_v;
    stat_vec_t st_v;

    spi_fis_level #(.DEPTH(DEPTH)) u_tx_lvl (
        .clk(clk), .rst(rst), .push(tx_push), .pop(tx_pop),
        .level(tx_level), .full(tx_full), .empty(tx_empty),
        .push_lost(tx_lost), .pop_starved(tx_starved_unused)
    );

    spi_fis_level #(.DEPTH(DEPTH)) u_rx_lvl (
        .clk(clk), .rst(rst), .push(rx_push), .pop(rx_pop),
        .level(rx_level), .full(rx_full), .empty(rx_empty),
        .push_lost(rx_lost), .pop_starved(rx_starved)
    );

    spi_fis_thresh #(.DEPTH(DEPTH)) u_tx_thr (
        .clk(clk), .rst(rst), .wr(tx_thr_wr), .wdata(thr_wdata), .thr(tx_thr)
    );

    spi_fis_thresh #(.DEPTH(DEPTH)) u_rx_thr (
        .clk(clk), .rst(rst), .wr(rx_thr_wr), .wdata(thr_wdata), .thr(rx_thr)
    );

    spi_fis_irq u_irq (
        .clk(clk), .rst(rst),
        .tx_level(tx_level), .rx_level(rx_level),
        .tx_thr(tx_thr), .rx_thr(rx_thr),
        .ev_tx_ovf(tx_lost), .ev_rx_unf(rx_starved), .ev_rx_ovf(rx_lost),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .clr_wr(clr_wr), .clr_wdata(clr_wdata),
        .mask_q(irq_mask), .raw(raw_v), .enabled(en_v)
    );

    always_comb begin
        st_v.busy     = engine_busy || !tx_empty;
        st_v.tx_full  = tx_full;
        st_v.tx_empty = tx_empty;
        st_v.rx_empty = rx_empty;
        st_v.rx_full  = rx_full;
    end

    assign raw_irq    = raw_v;
    assign masked_irq = en_v;
    assign irq        = |en_v;
    assign status     = st_v;
endmodule

// File: rtl/spi_fis_chk.sv
module spi_fis_chk #(
    parameter int DEPTH = 16
) (
    input logic       clk,
    input logic       rst,
    input logic       tx_push,
    input logic       rx_push,
    input logic       rx_pop,
    input logic       tx_thr_wr,
    input logic [4:0] thr_wdata,
    input logic       clr_wr,
    input logic [3:0] clr_wdata,
    input logic [4:0] tx_level,
    input logic [4:0] rx_level,
    input logic [4:0] tx_thr,
    input logic [4:0] irq_mask,
    input logic [4:0] raw_irq,
    input logic       irq
);
    // R2
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(tx_level) <= DEPTH) && (int'(rx_level) <= DEPTH));

    // R3
    tx_ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_push && int'(tx_level) == DEPTH) |=> (raw_irq[1] && $stable(tx_level)));

    // R4
    rx_unf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_pop && rx_level == 5'd0) |=> (raw_irq[2] && rx_level == 5'd0));

    // R5
    rx_ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_push && int'(rx_level) == DEPTH) |=> raw_irq[3]);

    // R6
    tx_ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (raw_irq[1] && !(clr_wr && (clr_wdata[0] || clr_wdata[3]))) |=> raw_irq[1]);

    // R9
    thr_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_thr_wr && int'(thr_wdata) >= DEPTH) |=> $stable(tx_thr));

    // R10
    irq_combine_chk: assert property (@(posedge clk) disable iff (rst)
        irq == ((raw_irq & irq_mask) != 5'd0));
endmodule

bind spi_fis_top spi_fis_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .tx_push(tx_push), .rx_push(rx_push), .rx_pop(rx_pop),
    .tx_thr_wr(tx_thr_wr), .thr_wdata(thr_wdata), .clr_wr(clr_wr), .clr_wdata(clr_wdata),
    .tx_level(tx_level), .rx_level(rx_level), .tx_thr(tx_thr), .irq_mask(irq_mask),
    .raw_irq(raw_irq), .irq(irq)
);

// File: tb/spi_fis_top_bench.sv
`timescale 1ns/1ps
module spi_fis_top_bench;
    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0, engine_busy = 0;
    logic tx_thr_wr = 0, rx_thr_wr = 0, mask_wr = 0, clr_wr = 0;
    logic [4:0] thr_wdata = 0, mask_wdata = 0;
    logic [3:0] clr_wdata = 0;
    logic [4:0] tx_level, rx_level, tx_thr, rx_thr, irq_mask, raw_irq, masked_irq, status;
    logic irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    spi_fis_top #(.DEPTH(DEPTH)) u_spi_fis_top (
        .clk(clk), .rst(rst), .tx_push(tx_push), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_pop(rx_pop), .engine_busy(engine_busy),
        .tx_thr_wr(tx_thr_wr), .rx_thr_wr(rx_thr_wr), .thr_wdata(thr_wdata),
        .mask_wr(mask_wr), .mask_wdata(mask_wdata), .clr_wr(clr_wr), .clr_wdata(clr_wdata),
        .tx_level(tx_level), .rx_level(rx_level), .tx_thr(tx_thr), .rx_thr(rx_thr),
        .irq_mask(irq_mask), .raw_irq(raw_irq), .masked_irq(masked_irq), .irq(irq),
        .status(status)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // strobes set before the call are seen at one edge, then dropped
    task automatic tick();
        @(negedge clk);
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
        tx_thr_wr = 0; rx_thr_wr = 0; mask_wr = 0; clr_wr = 0;
    endtask

    task automatic clear(input logic [3:0] v);
        clr_wr = 1; clr_wdata = v; tick();
    endtask

    task automatic t_reset();
        chk("R1 tx_level", tx_level, 0);
        chk("R1 rx_level", rx_level, 0);
        chk("R1 thresholds", {tx_thr, rx_thr}, 0);
        chk("R1 mask", irq_mask, 0);
        chk("R1 raw", raw_irq, 5'b00001);
        chk("R1 irq", irq, 0);
        chk("R1 status", status, 5'b01100);
        engine_busy = 1; #1;
        chk("R11 busy from engine", status[0], 1);
        engine_busy = 0;
    endtask

    task automatic t_tx_fill();
        for (int i = 0; i < DEPTH; i++) begin tx_push = 1; tick(); end
        chk("R2 tx fills", tx_level, DEPTH);
        chk("R11 status tx full", status, 5'b01011);
        chk("R7 tx above thr", raw_irq[0], 0);
        tx_push = 1; tick();
        chk("R3 tx level held", tx_level, DEPTH);
        chk("R3 tx overflow bit", raw_irq[1], 1);
        tx_pop = 1; tick();
        chk("R2 tx pop", tx_level, DEPTH - 1);
        clear(4'b0110);
        chk("R6 other clears keep tx ovf", raw_irq[1], 1);
        clear(4'b1000);
        chk("R6 tx ovf cleared", raw_irq[1], 0);
        for (int i = 0; i < DEPTH - 1; i++) begin tx_pop = 1; tick(); end
        chk("R2 tx drained", tx_level, 0);
        chk("R7 tx at thr", raw_irq[0], 1);
    endtask

    task automatic t_rx_errors();
        rx_pop = 1; tick();
        chk("R4 rx level stays 0", rx_level, 0);
        chk("R4 rx underflow bit", raw_irq[2], 1);
        for (int i = 0; i < DEPTH + 1; i++) begin rx_push = 1; tick(); end
        chk("R5 rx level capped", rx_level, DEPTH);
        chk("R5 rx overflow bit", raw_irq[3], 1);
        chk("R11 status rx full", status, 5'b10100);
        chk("R8 rx above thr 0", raw_irq[4], 1);
        clear(4'b0010);
        chk("R6 unf cleared only", raw_irq[3:2], 2'b10);
        clear(4'b0100);
        chk("R6 rov cleared", raw_irq[3], 0);
    endtask

    task automatic t_thresh();
        thr_wdata = 5'd16; rx_thr_wr = 1; tick();
        chk("R9 depth value rejected", rx_thr, 0);
        thr_wdata = 5'd31; tx_thr_wr = 1; tick();
        chk("R9 large value rejected", tx_thr, 0);
        thr_wdata = 5'd15; rx_thr_wr = 1; tick();
        chk("R9 legal value stored", rx_thr, 15);
        chk("R8 16 over 15", raw_irq[4], 1);
        rx_pop = 1; tick();
        chk("R8 15 not over 15", raw_irq[4], 0);
        thr_wdata = 5'd4; tx_thr_wr = 1; tick();
        for (int i = 0; i < 4; i++) begin tx_push = 1; tick(); end
        chk("R7 tx 4 at thr 4", raw_irq[0], 1);
        tx_push = 1; tick();
        chk("R7 tx 5 over thr 4", raw_irq[0], 0);
    endtask

    task automatic t_mask_and_clear();
        for (int i = 0; i < DEPTH - 1; i++) begin rx_pop = 1; tick(); end
        rx_pop = 1; tick();
        chk("R4 underflow again", raw_irq[2], 1);
        mask_wdata = 5'b00100; mask_wr = 1; tick();
        chk("R10 masked vector", masked_irq, 5'b00100);
        chk("R10 irq high", irq, 1);
        mask_wdata = 5'b10001; mask_wr = 1; tick();
        chk("R10 irq low when disabled", irq, 0);
        rx_pop = 1; clr_wr = 1; clr_wdata = 4'b0010; tick();
        chk("R6 event wins over clear", raw_irq[2], 1);
        clear(4'b0001);
        chk("R6 clear all", raw_irq[3:1], 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_tx_fill();
        t_rx_errors();
        t_thresh();
        t_mask_and_clear();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=hang expected=finish");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule